// File: doc/BRIEF.md
# GPIO Pad Event Interrupt Controller

A bank of general-purpose pads that share one interrupt group. Each pad has its own 32-bit configuration word. The word sets the output value, enables or disables the transmit and receive buffers, selects a pad function and chooses how input activity turns into an interrupt event. The received signal passes through a two-flop synchronizer. It can then be inverted before event detection, so one 2-bit event field plus the inversion bit covers high level, low level, rising edge, falling edge and both edges.

Detected events latch into a group status word with one bit per pad. Software clears a bit by writing 1 to it. A group enable word gates the status bits, and a registered interrupt line goes high while any enabled status bit is set. A plain register port gives access to the configuration words, the status word, the enable word and a word that holds each pad's logical value. The port is a write strobe with address and data, plus a read path with one cycle of latency.

Register addresses (word index): pad configuration words at 0 to NUM_PADS-1, status at 32, enable at 33, logical value at 34. All other addresses read as zero.

Top module: `gpio_evt_ctrl`

## Requirements
- R1: After reset, status, enable and `irq` are 0, no pad drives (`pad_oe` all 0), and every configuration word reads 0x0400_0100: events disabled, transmit disabled, receive enabled.
- R2: In a configuration word, bit 0 is the output value driven on `pad_out`, and `pad_oe` is high exactly when bit 8 (transmit disable) is 0.
- R3: Bit 1 of a configuration word reads the synchronized pad input, and it reads 0 while bit 9 (receive disable) is set. Writes to bit 1 are ignored.
- R4: Bit i of the logical-value word (address 34) returns bit 0 of pad i's configuration when transmit is enabled, and the received state (bit 1) otherwise.
- R5: With event field bits 26:25 = 0 (level), the status bit is set on every cycle while the received signal, XORed with bit 23 (invert), is 1. A clear does not hold while that level persists. With inversion set, a low input is the active level.
- R6: With event field = 1 (single edge), only a 0-to-1 transition of the received signal after inversion sets status. Without inversion this is the rising input edge; with bit 23 set it is the falling input edge.
- R7: With event field = 3, both edges of the input set status.
- R8: Event field = 2, or a pad function field (bits 13:10) other than 0, produces no status bit at all.
- R9: Writing the status word (address 32) clears each bit written as 1. Bits written as 0 keep their value.
- R10: The enable word is at address 33. `irq` is the registered OR of status AND enable, so it follows one cycle after them.
- R11: When an event and a software clear hit the same status bit in the same cycle, the bit ends set.
- R12: `reg_rdata` shows the register selected by `reg_addr` one clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_in | input | NUM_PADS | Asynchronous pad inputs |
| pad_out | output | NUM_PADS | Output values to the pads |
| pad_oe | output | NUM_PADS | Output-enable for each pad |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Group interrupt, registered |

## Verification
Two functions can meet on the same status bit in the same cycle: the hardware event that sets it and the software write-1 that clears it. The bench provokes this with a pad in rising-edge mode. It raises the pad on a falling clock edge, counts the two synchronizer stages, and issues the status write so that it lands on the very edge where the detect pulse is captured. After that edge it reads status and expects the bit to be set. A clear issued one cycle later must then leave the bit at 0, which shows that the bit stayed set because the set won, and not because the write was lost.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  localparam int CFG_W     = 32;
  localparam int B_TXVAL   = 0;
  localparam int B_RXST    = 1;
  localparam int B_TXDIS   = 8;
  localparam int B_RXDIS   = 9;
  localparam int B_FUNC_LO = 10;
  localparam int B_FUNC_HI = 13;
  localparam int B_INV     = 23;
  localparam int B_EVT_LO  = 25;
  localparam int B_EVT_HI  = 26;

  typedef enum logic [1:0] {
    EVT_LEVEL = 2'd0,
    EVT_EDGE  = 2'd1,
    EVT_OFF   = 2'd2,
    EVT_BOTH  = 2'd3
  } evt_sel_e;

  typedef struct packed {
    logic [1:0] evt;
    logic       inv;
    logic [3:0] func;
    logic       rxdis;
    logic       txdis;
    logic       txval;
  } pad_cfg_t;

  localparam pad_cfg_t CFG_RST = '{evt: EVT_OFF, inv: 1'b0, func: 4'd0,
                                   rxdis: 1'b0, txdis: 1'b1, txval: 1'b0};

  function automatic pad_cfg_t cfg_from_word(input logic [CFG_W-1:0] w);
    pad_cfg_t c;
    c.evt   = w[B_EVT_HI:B_EVT_LO];
    c.inv   = w[B_INV];
    c.func  = w[B_FUNC_HI:B_FUNC_LO];
    c.rxdis = w[B_RXDIS];
    c.txdis = w[B_TXDIS];
    c.txval = w[B_TXVAL];
    return c;
  endfunction

  function automatic logic [CFG_W-1:0] cfg_to_word(input pad_cfg_t c,
                                                   input logic rx_state);
    logic [CFG_W-1:0] w;
    w                      = '0;
    w[B_EVT_HI:B_EVT_LO]   = c.evt;
    w[B_INV]               = c.inv;
    w[B_FUNC_HI:B_FUNC_LO] = c.func;
    w[B_RXDIS]             = c.rxdis;
    w[B_TXDIS]             = c.txdis;
    w[B_RXST]              = rx_state;
    w[B_TXVAL]             = c.txval;
    return w;
  endfunction

endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/gpio_evt_pad.sv
module gpio_evt_pad
  import gpio_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  pad_cfg_t         cfg_wr,
  input  logic             rx_sync,
  output logic [CFG_W-1:0] cfg_word,
  output logic             pad_out,
  output logic             pad_oe,
  output logic             logic_val,
  output logic             evt
);

  pad_cfg_t cfg_q;
  logic     rx_state;
  logic     sig;
  logic     sig_prev_q;
  logic     hit;
  logic     gpio_fn;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= CFG_RST;
    else if (cfg_we) cfg_q <= cfg_wr;
  end

  assign rx_state  = rx_sync & ~cfg_q.rxdis;
  assign sig       = rx_state ^ cfg_q.inv;
  assign gpio_fn   = (cfg_q.func == 4'd0);

  always_ff @(posedge clk) begin
    if (rst) sig_prev_q <= 1'b0;
    else     sig_prev_q <= sig;
  end

  always_comb begin
    case (evt_sel_e'(cfg_q.evt))
      EVT_LEVEL: hit = sig;
      EVT_EDGE:  hit = sig & ~sig_prev_q;
      EVT_BOTH:  hit = sig ^ sig_prev_q;
      default:   hit = 1'b0;
    endcase
  end

  assign evt       = gpio_fn & hit;
  assign pad_out   = cfg_q.txval;
  assign pad_oe    = ~cfg_q.txdis;
  assign logic_val = cfg_q.txdis ? rx_state : cfg_q.txval;
  assign cfg_word  = cfg_to_word(cfg_q, rx_state);

endmodule

// File: rtl/gpio_evt_group.sv
module gpio_evt_group #(
  parameter int NUM_PADS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PADS-1:0] evt_vec,
  input  logic                stat_we,
  input  logic                en_we,
  input  logic [NUM_PADS-1:0] wr_bits,
  output logic [NUM_PADS-1:0] stat_q,
  output logic [NUM_PADS-1:0] en_q,
  output logic                irq
);

  logic [NUM_PADS-1:0] clr_mask;

  assign clr_mask = stat_we ? wr_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      en_q   <= '0;
      irq    <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr_mask) | evt_vec;
      if (en_we) en_q <= wr_bits;
      irq    <= |(stat_q & en_q);
    end
  end

endmodule

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PADS    = 8,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                irq
);

  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(32);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(33);
  localparam logic [ADDR_W-1:0] A_VAL  = ADDR_W'(34);

  logic [NUM_PADS-1:0] rx_sync;
  logic [NUM_PADS-1:0] evt_vec;
  logic [NUM_PADS-1:0] logic_vec;
  logic [NUM_PADS-1:0] stat_q;
  logic [NUM_PADS-1:0] en_q;
  logic [CFG_W-1:0]    cfg_words [NUM_PADS];
  pad_cfg_t            cfg_wr;
  logic [31:0]         rd_mux;
  logic                unused_wbits;

  assign cfg_wr       = cfg_from_word(reg_wdata);
  assign unused_wbits = ^reg_wdata;

  gpio_evt_sync #(.WIDTH(NUM_PADS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (pad_in),
    .q_sync  (rx_sync)
  );

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
    gpio_evt_pad u_pad (
      .clk       (clk),
      .rst       (rst),
      .cfg_we    (reg_we && (reg_addr == ADDR_W'(i))),
      .cfg_wr    (cfg_wr),
      .rx_sync   (rx_sync[i]),
      .cfg_word  (cfg_words[i]),
      .pad_out   (pad_out[i]),
      .pad_oe    (pad_oe[i]),
      .logic_val (logic_vec[i]),
      .evt       (evt_vec[i])
    );
  end

  gpio_evt_group #(.NUM_PADS(NUM_PADS)) u_group (
    .clk     (clk),
    .rst     (rst),
    .evt_vec (evt_vec),
    .stat_we (reg_we && (reg_addr == A_STAT)),
    .en_we   (reg_we && (reg_addr == A_EN)),
    .wr_bits (reg_wdata[NUM_PADS-1:0]),
    .stat_q  (stat_q),
    .en_q    (en_q),
    .irq     (irq)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_PADS; i++) begin
      if (reg_addr == ADDR_W'(i)) rd_mux = cfg_words[i];
    end
    if (reg_addr == A_STAT) rd_mux = 32'(stat_q);
    if (reg_addr == A_EN)   rd_mux = 32'(en_q);
    if (reg_addr == A_VAL)  rd_mux = 32'(logic_vec);
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

endmodule

// File: rtl/gpio_evt_chk.sv
module gpio_evt_chk #(
  parameter int NUM_PADS = 8,
  parameter int ADDR_W   = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                reg_we,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [NUM_PADS-1:0] wbits,
  input logic [NUM_PADS-1:0] evt_vec,
  input logic [NUM_PADS-1:0] stat_q,
  input logic [NUM_PADS-1:0] en_q,
  input logic                irq
);

  logic stat_wr;
  assign stat_wr = reg_we && (reg_addr == ADDR_W'(32));

  // R10: interrupt is the registered OR of enabled status bits
  p_irq_follows_r10: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq == $past(|(stat_q & en_q))));

  // R9: a bit written 1 with no event that cycle ends cleared
  p_w1c_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (!rst && stat_wr) |=> ((stat_q & $past(wbits & ~evt_vec)) == '0));

  // R9: bits written 0 keep their value (plus any new event)
  p_w0_keeps_r9: assert property (@(posedge clk) disable iff (rst)
    (!rst && stat_wr) |=> ((stat_q & ~$past(wbits)) ==
                           ($past(stat_q | evt_vec) & ~$past(wbits))));

  // R11: an event always leaves its status bit set, clear or not
  p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((stat_q & $past(evt_vec)) == $past(evt_vec)));

  // R8: no status bit rises without an event
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((stat_q & ~$past(stat_q) & ~$past(evt_vec)) == '0));

endmodule

bind gpio_evt_ctrl gpio_evt_chk #(.NUM_PADS(NUM_PADS), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .wbits    (reg_wdata[NUM_PADS-1:0]),
  .evt_vec  (evt_vec),
  .stat_q   (stat_q),
  .en_q     (en_q),
  .irq      (irq)
);

// File: tb/tb_gpio_evt_ctrl.sv
module tb_gpio_evt_ctrl;

  localparam int N  = 8;
  localparam int AW = 6;
  localparam logic [AW-1:0] A_STAT = 6'd32;
  localparam logic [AW-1:0] A_EN   = 6'd33;
  localparam logic [AW-1:0] A_VAL  = 6'd34;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  pad_in = '0;
  logic [N-1:0]  pad_out, pad_oe;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #5 clk = ~clk;

  gpio_evt_ctrl #(.NUM_PADS(N), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  task automatic set_pad(input int p, input logic v);
    @(negedge clk);
    pad_in[p] = v;
    settle();
  endtask

  task automatic stat_bit(input int p, output logic [31:0] b);
    logic [31:0] d;
    rd(A_STAT, d);
    b = (d >> p) & 32'd1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", 32'(irq), 0);
    check("R1 pad_oe", 32'(pad_oe), 0);
    rd(6'd0, d);      check("R1 cfg0", d, 32'h0400_0100);
    rd(6'd7, d);      check("R1 cfg7", d, 32'h0400_0100);
    rd(A_STAT, d);    check("R1 status", d, 0);
    rd(A_EN, d);      check("R1 enable", d, 0);
  endtask

  task automatic t_output();
    logic [31:0] d;
    wr(6'd1, 32'h0400_0001);
    check("R2 pad_out", 32'(pad_out[1]), 1);
    check("R2 pad_oe", 32'(pad_oe[1]), 1);
    rd(A_VAL, d);     check("R4 value from txval", (d >> 1) & 1, 1);
    wr(6'd1, 32'h0400_0100);
    check("R2 pad_oe off", 32'(pad_oe[1]), 0);
    check("R2 pad_out held", 32'(pad_out[1]), 0);
  endtask

  task automatic t_input();
    logic [31:0] d;
    wr(6'd2, 32'h0400_0101);
    set_pad(2, 1'b1);
    rd(6'd2, d);      check("R3 rx state", d, 32'h0400_0103);
    rd(A_VAL, d);     check("R4 value from rx, tx disabled", (d >> 2) & 1, 1);
    wr(6'd2, 32'h0400_0002);
    rd(6'd2, d);      check("R3 bit1 not writable, reads rx", d, 32'h0400_0002);
    rd(A_VAL, d);     check("R4 value from txval 0", (d >> 2) & 1, 0);
    wr(6'd2, 32'h0400_0300);
    rd(6'd2, d);      check("R3 rx disabled reads 0", d, 32'h0400_0300);
    rd(A_VAL, d);     check("R4 value rx disabled", (d >> 2) & 1, 0);
    set_pad(2, 1'b0);
  endtask

  task automatic t_level();
    logic [31:0] b;
    set_pad(3, 1'b1);
    wr(6'd3, 32'h0000_0100);
    settle();
    stat_bit(3, b);   check("R5 level high sets", b, 1);
    wr(A_STAT, 32'h08);
    stat_bit(3, b);   check("R5 clear does not hold", b, 1);
    set_pad(3, 1'b0);
    wr(A_STAT, 32'h08);
    stat_bit(3, b);   check("R5 clear after level gone", b, 0);
    wr(6'd3, 32'h0080_0100);
    settle();
    stat_bit(3, b);   check("R5 active-low level sets", b, 1);
    wr(6'd3, 32'h0400_0100);
    wr(A_STAT, 32'h08);
    stat_bit(3, b);   check("R5 cleared after disable", b, 0);
  endtask

  task automatic t_edge();
    logic [31:0] b;
    wr(6'd4, 32'h0200_0100);
    settle();
    wr(A_STAT, 32'hFF);
    set_pad(4, 1'b1);
    stat_bit(4, b);   check("R6 rising edge sets", b, 1);
    wr(A_STAT, 32'h10);
    set_pad(4, 1'b0);
    stat_bit(4, b);   check("R6 falling ignored without invert", b, 0);
    wr(6'd4, 32'h0280_0100);
    settle();
    wr(A_STAT, 32'h10);
    set_pad(4, 1'b1);
    stat_bit(4, b);   check("R6 rising ignored with invert", b, 0);
    set_pad(4, 1'b0);
    stat_bit(4, b);   check("R6 falling edge with invert sets", b, 1);
    wr(6'd4, 32'h0200_0100);
    settle();
    wr(A_STAT, 32'h10);
  endtask

  task automatic t_both();
    logic [31:0] b;
    wr(6'd5, 32'h0600_0100);
    settle();
    wr(A_STAT, 32'h20);
    set_pad(5, 1'b1);
    stat_bit(5, b);   check("R7 both: rise sets", b, 1);
    wr(A_STAT, 32'h20);
    stat_bit(5, b);   check("R7 both: clears while steady", b, 0);
    set_pad(5, 1'b0);
    stat_bit(5, b);   check("R7 both: fall sets", b, 1);
    wr(A_STAT, 32'h20);
  endtask

  task automatic t_disabled();
    logic [31:0] b;
    set_pad(6, 1'b1);
    set_pad(6, 1'b0);
    stat_bit(6, b);   check("R8 event field 2 ignores toggles", b, 0);
    wr(6'd6, 32'h0600_0500);
    settle();
    set_pad(6, 1'b1);
    set_pad(6, 1'b0);
    stat_bit(6, b);   check("R8 non-GPIO function ignores edges", b, 0);
    wr(6'd6, 32'h0000_0500);
    set_pad(6, 1'b1);
    stat_bit(6, b);   check("R8 non-GPIO function ignores level", b, 0);
    wr(6'd6, 32'h0400_0100);
    set_pad(6, 1'b0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(6'd7, 32'h0200_0100);
    settle();
    wr(A_STAT, 32'hFF);
    set_pad(7, 1'b1);
    check("R10 no irq while disabled", 32'(irq), 0);
    wr(A_EN, 32'h80);
    repeat (2) @(negedge clk);
    check("R10 irq when status and enable", 32'(irq), 1);
    rd(A_EN, d);      check("R10 enable readback", d, 32'h80);
    wr(A_STAT, 32'h80);
    repeat (2) @(negedge clk);
    check("R10 irq drops after clear", 32'(irq), 0);
    set_pad(7, 1'b0);
  endtask

  task automatic t_setwins();
    logic [31:0] b;
    wr(A_STAT, 32'hFF);
    @(negedge clk);
    pad_in[4] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h10;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
    stat_bit(4, b);   check("R11 set beats clear", b, 1);
    wr(A_STAT, 32'h10);
    stat_bit(4, b);   check("R9 write 1 clears", b, 0);
    set_pad(4, 1'b0);
  endtask

  task automatic t_w0();
    logic [31:0] d;
    wr(6'd5, 32'h0600_0100);
    set_pad(5, 1'b1);
    set_pad(4, 1'b1);
    wr(A_STAT, 32'h10);
    rd(A_STAT, d);    check("R9 written-0 bit kept", d & 32'h30, 32'h20);
    wr(A_STAT, 32'h20);
    set_pad(4, 1'b0);
    set_pad(5, 1'b0);
    wr(A_STAT, 32'hFF);
  endtask

  task automatic t_latency();
    wr(A_EN, 32'hA5);
    @(negedge clk);
    reg_addr = 6'd0;
    @(negedge clk);
    reg_addr = A_EN;
    #1;
    check("R12 data not yet changed", reg_rdata, 32'h0400_0100);
    @(posedge clk);
    @(negedge clk);
    check("R12 data after one edge", reg_rdata, 32'hA5);
    wr(A_EN, 32'h00);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_output();
    t_input();
    t_level();
    t_edge();
    t_both();
    t_disabled();
    t_irq();
    t_setwins();
    t_w0();
    t_latency();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule